// File: doc/BRIEF.md
# Per-Cache Coherence Line Controller

This block is the coherence engine of one private cache in a directory-based protocol. Each line is Invalid, Shared or Exclusive. It holds a small direct-mapped array of lines. Each line stores the full memory address as its tag, one data word, a coherence state and a busy flag. The processor sends five kinds of operation on one valid/ready channel:

- read and write, which finish locally in one cycle, as a hit or as a miss;
- eviction, read-for-shared and read-for-exclusive, which are sent to the directory and finish later.

The directory talks back on a command port. It sends fill responses, eviction acknowledgements, and two kinds of invalidate. The shared invalidate only rewrites the line state. The exclusive invalidate rewrites the state and also returns the line's data.

A controller with two states does the processor-side sequencing. `FSM_IDLE` takes new processor operations. `FSM_ISSUE` holds one outgoing directory request until the directory accepts it. There are two transitions:

- IDLE to ISSUE (`launch`): an accepted eviction of a valid matching line, or an accepted fill request.
- ISSUE to IDLE (`handshake`): `d_req_valid` and `d_req_ready` are both high at a clock edge.

The busy flag of a line stays set from the moment its request is launched until the directory's matching response arrives. While it is set, new processor operations to that index wait.

Top module: `coh_line_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every line is Invalid and not busy, no output pulse is raised, and `p_ready` is high when `c_valid` is low.
- R2: The line index is the XOR of all IDX_W-bit slices of the address (for 8-bit addresses and 4 lines: a[1:0]^a[3:2]^a[5:4]^a[7:6]). The stored tag is the full address, so two addresses that share an index never hit for each other.
- R3: A read (op 0) that is accepted at edge k raises `p_done` for the cycle after k. `p_hit`=1 and `p_rdata` equals the line data only when the tag matches and the state is Shared (1) or Exclusive (2). Otherwise `p_hit`=0 and `p_rdata`=0.
- R4: A write (op 1) hits and replaces the line data only when the tag matches and the state is Exclusive. Any other write reports a miss and leaves the line unchanged.
- R5: Three operations mark the line busy and raise `d_req_valid` with `d_req_addr`: an eviction (op 2) of a matching non-Invalid line, a read-shared (op 3) and a read-exclusive (op 4). `d_req_kind` is evict=0, shared=1 or exclusive=2, and `d_req_data` carries the line data for an eviction and 0 otherwise. The request is held stable until `d_req_ready`. `p_done`=`p_hit`=1 follows one cycle after the handshake. An eviction that does not match finishes as a miss one cycle after acceptance and issues no request.
- R6: A fill command (`c_kind`=0) writes the tag `c_addr`, the data `c_data` and the state `c_state` into the indexed line, and clears its busy flag.
- R7: A shared invalidate (`c_kind`=2) sets the line state to `c_state` when the tag matches `c_addr`, and returns no data (`c_rvalid` stays 0).
- R8: An exclusive invalidate (`c_kind`=3) raises `c_rvalid` for the next cycle, with `c_rdata` equal to the line's data before the command. It sets the state to `c_state` when the tag matches.
- R9: `p_ready` is low while the addressed line is busy, while a directory request is pending, and while `c_valid` is high.
- R10: An eviction acknowledgement (`c_kind`=1) clears the busy flag and sets the line Invalid when the tag matches.
- R11: Op codes 5 to 7 finish one cycle after acceptance with `p_hit`=0 and change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_valid | input | 1 | Processor operation valid |
| p_ready | output | 1 | Processor operation accepted this cycle |
| p_op | input | 3 | Operation code |
| p_addr | input | ADDR_W | Operation address |
| p_wdata | input | DATA_W | Write data |
| p_done | output | 1 | Operation finished (one-cycle pulse) |
| p_hit | output | 1 | Operation was performed |
| p_rdata | output | DATA_W | Read data on a read hit |
| d_req_valid | output | 1 | Directory request valid |
| d_req_ready | input | 1 | Directory request accepted |
| d_req_kind | output | 2 | Evict / shared / exclusive |
| d_req_addr | output | ADDR_W | Request address |
| d_req_data | output | DATA_W | Eviction data |
| c_valid | input | 1 | Directory command valid |
| c_kind | input | 2 | Fill / evict ack / shared invalidate / exclusive invalidate |
| c_addr | input | ADDR_W | Command address |
| c_state | input | 2 | Granted or commanded state |
| c_data | input | DATA_W | Fill data |
| c_rvalid | output | 1 | Data return from an exclusive invalidate |
| c_rdata | output | DATA_W | Returned line data |

## Verification
The assertions check four things on every cycle:

- a busy line never receives a second launch;
- a fill always leaves its line not busy;
- a pending directory request holds its fields until accepted, and its completion pulse follows the handshake;
- data is returned exactly when an exclusive invalidate arrived.

Other behaviours show only in the bench's scenarios, because they depend on the history of a line:

- the hit or miss decision from tag and state;
- address aliasing through the index hash;
- the effect of downgrades on later writes;
- an eviction acknowledgement invalidating the line.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHD = 2'd1,
        ST_EXC = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_EVICT   = 3'd2,
        OP_GET_SHD = 3'd3,
        OP_GET_EXC = 3'd4
    } proc_op_e;

    typedef enum logic [1:0] {
        DREQ_EVICT = 2'd0,
        DREQ_SHD   = 2'd1,
        DREQ_EXC   = 2'd2
    } dir_req_e;

    typedef enum logic [1:0] {
        CMD_FILL      = 2'd0,
        CMD_EVICT_ACK = 2'd1,
        CMD_INV_SHD   = 2'd2,
        CMD_INV_EXC   = 2'd3
    } dir_cmd_e;

    typedef enum logic {
        FSM_IDLE  = 1'b0,
        FSM_ISSUE = 1'b1
    } fsm_e;
endpackage

// File: rtl/coh_index_hash.sv
module coh_index_hash #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int SLICES = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = SLICES * IDX_W;

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(addr);

    always_comb begin
        idx = '0;
        for (int s = 0; s < SLICES; s++) begin
            idx = idx ^ padded[s*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/coh_line_array.sv
module coh_line_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [ADDR_W-1:0] a_tag,
    output logic [DATA_W-1:0] a_data,
    output logic [1:0]        a_st,
    output logic              a_busy,
    input  logic              wd_en,
    input  logic [DATA_W-1:0] wd_data,
    input  logic              bset_en,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [ADDR_W-1:0] b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              st_en,
    input  logic [1:0]        st_val,
    input  logic              bclr_en
);
    import coh_pkg::*;
    localparam int LINES = 1 << IDX_W;

    logic [ADDR_W-1:0] tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [1:0]        st_q   [LINES];
    logic [LINES-1:0]  busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            for (int l = 0; l < LINES; l++) begin
                tag_q[l]  <= '0;
                data_q[l] <= '0;
                st_q[l]   <= ST_INV;
            end
        end else begin
            if (wd_en)   data_q[a_idx] <= wd_data;
            if (bset_en) busy_q[a_idx] <= 1'b1;
            if (fill_en) begin
                tag_q[b_idx]  <= fill_tag;
                data_q[b_idx] <= fill_data;
            end
            if (st_en)   st_q[b_idx]   <= st_val;
            if (bclr_en) busy_q[b_idx] <= 1'b0;
        end
    end

    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign a_st   = st_q[a_idx];
    assign a_busy = busy_q[a_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    // R9
    no_busy_relaunch_chk: assert property (@(posedge clk) disable iff (rst)
        bset_en |-> !a_busy);

    // R6
    fill_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && bclr_en) |=> !busy_q[$past(b_idx)]);
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p_valid,
    input  logic [2:0]        p_op,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0] p_wdata,
    input  logic              c_valid,
    input  logic [ADDR_W-1:0] l_tag,
    input  logic [DATA_W-1:0] l_data,
    input  logic [1:0]        l_st,
    input  logic              l_busy,
    input  logic              d_req_ready,
    output logic              p_ready,
    output logic              p_done,
    output logic              p_hit,
    output logic [DATA_W-1:0] p_rdata,
    output logic              d_req_valid,
    output logic [1:0]        d_req_kind,
    output logic [ADDR_W-1:0] d_req_addr,
    output logic [DATA_W-1:0] d_req_data,
    output logic              wd_en,
    output logic [DATA_W-1:0] wd_data,
    output logic              bset_en
);
    import coh_pkg::*;

    fsm_e              state_q, state_n;
    logic              accept, tag_hit, launch;
    logic              done_n, hit_n;
    logic [DATA_W-1:0] rdata_n, req_data_n;
    logic [1:0]        req_kind_n;
    logic [1:0]        req_kind_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_data_q;

    assign tag_hit = (l_tag == p_addr);
    assign p_ready = (state_q == FSM_IDLE) && !l_busy && !c_valid;
    assign accept  = p_valid && p_ready;
    assign wd_data = p_wdata;

    always_comb begin
        state_n    = state_q;
        done_n     = 1'b0;
        hit_n      = 1'b0;
        rdata_n    = '0;
        wd_en      = 1'b0;
        launch     = 1'b0;
        req_kind_n = DREQ_SHD;
        req_data_n = '0;
        unique case (state_q)
            FSM_IDLE: begin
                if (accept) begin
                    case (p_op)
                        OP_READ: begin
                            done_n = 1'b1;
                            hit_n  = tag_hit && (l_st != ST_INV);
                            if (hit_n) rdata_n = l_data;
                        end
                        OP_WRITE: begin
                            done_n = 1'b1;
                            hit_n  = tag_hit && (l_st == ST_EXC);
                            wd_en  = hit_n;
                        end
                        OP_EVICT: begin
                            if (tag_hit && (l_st != ST_INV)) begin
                                launch     = 1'b1;
                                req_kind_n = DREQ_EVICT;
                                req_data_n = l_data;
                            end else begin
                                done_n = 1'b1;
                            end
                        end
                        OP_GET_SHD: begin
                            launch     = 1'b1;
                            req_kind_n = DREQ_SHD;
                        end
                        OP_GET_EXC: begin
                            launch     = 1'b1;
                            req_kind_n = DREQ_EXC;
                        end
                        default: done_n = 1'b1;
                    endcase
                    if (launch) state_n = FSM_ISSUE;
                end
            end
            FSM_ISSUE: begin
                if (d_req_ready) begin
                    state_n = FSM_IDLE;
                    done_n  = 1'b1;
                    hit_n   = 1'b1;
                end
            end
        endcase
    end

    assign bset_en = launch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FSM_IDLE;
            req_kind_q <= DREQ_EVICT;
            req_addr_q <= '0;
            req_data_q <= '0;
        end else begin
            state_q <= state_n;
            if (launch) begin
                req_kind_q <= req_kind_n;
                req_addr_q <= p_addr;
                req_data_q <= req_data_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_done  <= 1'b0;
            p_hit   <= 1'b0;
            p_rdata <= '0;
        end else begin
            p_done  <= done_n;
            p_hit   <= hit_n;
            p_rdata <= rdata_n;
        end
    end

    assign d_req_valid = (state_q == FSM_ISSUE);
    assign d_req_kind  = req_kind_q;
    assign d_req_addr  = req_addr_q;
    assign d_req_data  = req_data_q;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (d_req_valid && !d_req_ready) |=> (d_req_valid && $stable(d_req_addr)
            && $stable(d_req_kind) && $stable(d_req_data)));

    // R5
    done_after_handshake_chk: assert property (@(posedge clk) disable iff (rst)
        (d_req_valid && d_req_ready) |=> (p_done && p_hit));

    // R9
    no_accept_pending_chk: assert property (@(posedge clk) disable iff (rst)
        d_req_valid |-> !p_ready);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p_valid,
    output logic              p_ready,
    input  logic [2:0]        p_op,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0] p_wdata,
    output logic              p_done,
    output logic              p_hit,
    output logic [DATA_W-1:0] p_rdata,
    output logic              d_req_valid,
    input  logic              d_req_ready,
    output logic [1:0]        d_req_kind,
    output logic [ADDR_W-1:0] d_req_addr,
    output logic [DATA_W-1:0] d_req_data,
    input  logic              c_valid,
    input  logic [1:0]        c_kind,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [1:0]        c_state,
    input  logic [DATA_W-1:0] c_data,
    output logic              c_rvalid,
    output logic [DATA_W-1:0] c_rdata
);
    import coh_pkg::*;

    logic [IDX_W-1:0]  a_idx, b_idx;
    logic [ADDR_W-1:0] a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data, wd_data;
    logic [1:0]        a_st, st_val;
    logic              a_busy, wd_en, bset_en;
    logic              fill_en, st_en, bclr_en, tag_b_hit, xret;

    coh_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_p (
        .addr(p_addr), .idx(a_idx));
    coh_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_c (
        .addr(c_addr), .idx(b_idx));

    assign tag_b_hit = (b_tag == c_addr);
    assign fill_en   = c_valid && (c_kind == CMD_FILL);
    assign bclr_en   = c_valid && ((c_kind == CMD_FILL) || (c_kind == CMD_EVICT_ACK));
    assign st_en     = fill_en || (c_valid && (c_kind != CMD_FILL) && tag_b_hit);
    assign st_val    = (c_kind == CMD_EVICT_ACK) ? ST_INV : c_state;
    assign xret      = c_valid && (c_kind == CMD_INV_EXC);

    coh_line_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lines (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .a_tag(a_tag), .a_data(a_data), .a_st(a_st), .a_busy(a_busy),
        .wd_en(wd_en), .wd_data(wd_data), .bset_en(bset_en),
        .b_idx(b_idx), .b_tag(b_tag), .b_data(b_data),
        .fill_en(fill_en), .fill_tag(c_addr), .fill_data(c_data),
        .st_en(st_en), .st_val(st_val), .bclr_en(bclr_en));

    coh_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst),
        .p_valid(p_valid), .p_op(p_op), .p_addr(p_addr), .p_wdata(p_wdata),
        .c_valid(c_valid),
        .l_tag(a_tag), .l_data(a_data), .l_st(a_st), .l_busy(a_busy),
        .d_req_ready(d_req_ready),
        .p_ready(p_ready), .p_done(p_done), .p_hit(p_hit), .p_rdata(p_rdata),
        .d_req_valid(d_req_valid), .d_req_kind(d_req_kind),
        .d_req_addr(d_req_addr), .d_req_data(d_req_data),
        .wd_en(wd_en), .wd_data(wd_data), .bset_en(bset_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            c_rvalid <= 1'b0;
            c_rdata  <= '0;
        end else begin
            c_rvalid <= xret;
            c_rdata  <= xret ? b_data : '0;
        end
    end

    // R8
    xinv_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (c_valid && c_kind == CMD_INV_EXC) |=> c_rvalid);

    // R7
    no_spurious_return_chk: assert property (@(posedge clk) disable iff (rst)
        !(c_valid && c_kind == CMD_INV_EXC) |=> !c_rvalid);
endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst = 1'b1;
    logic        p_valid = 0, p_ready, p_done, p_hit;
    logic [2:0]  p_op = 0;
    logic [7:0]  p_addr = 0;
    logic [15:0] p_wdata = 0, p_rdata;
    logic        d_req_valid, d_req_ready = 0;
    logic [1:0]  d_req_kind;
    logic [7:0]  d_req_addr;
    logic [15:0] d_req_data;
    logic        c_valid = 0, c_rvalid;
    logic [1:0]  c_kind = 0, c_state = 0;
    logic [7:0]  c_addr = 0;
    logic [15:0] c_data = 0, c_rdata;

    coh_line_ctrl uut (.*);

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int hsh(logic [7:0] a);
        return int'(a[1:0] ^ a[3:2] ^ a[5:4] ^ a[7:6]);
    endfunction

    // reference model
    logic [7:0]  m_tag [4];
    logic [15:0] m_data [4];
    int          m_st [4];
    bit          m_busy [4];
    bit          m_issue;
    int          m_kind;
    logic [7:0]  m_raddr;
    logic [15:0] m_rdata;
    bit          e_done, e_hit, e_crv;
    logic [15:0] e_rdata, e_crd;

    always @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < 4; l++) begin
                m_tag[l] = 0; m_data[l] = 0; m_st[l] = 0; m_busy[l] = 0;
            end
            m_issue = 0; e_done = 0; e_hit = 0; e_rdata = 0; e_crv = 0; e_crd = 0;
        end else begin
            automatic int pi = hsh(p_addr);
            automatic int ci = hsh(c_addr);
            automatic bit acc = p_valid && !m_issue && !m_busy[pi] && !c_valid;
            automatic bit th = (m_tag[pi] == p_addr);
            e_done = 0; e_hit = 0; e_rdata = 0; e_crv = 0; e_crd = 0;
            if (c_valid) begin
                automatic bit cm = (m_tag[ci] == c_addr);
                case (c_kind)
                    0: begin m_tag[ci] = c_addr; m_data[ci] = c_data; m_st[ci] = c_state; m_busy[ci] = 0; end
                    1: begin m_busy[ci] = 0; if (cm) m_st[ci] = 0; end
                    2: if (cm) m_st[ci] = c_state;
                    default: begin e_crv = 1; e_crd = m_data[ci]; if (cm) m_st[ci] = c_state; end
                endcase
            end
            if (m_issue) begin
                if (d_req_ready) begin m_issue = 0; e_done = 1; e_hit = 1; end
            end else if (acc) begin
                case (p_op)
                    0: begin e_done = 1; e_hit = th && m_st[pi] != 0; if (e_hit) e_rdata = m_data[pi]; end
                    1: begin e_done = 1; e_hit = th && m_st[pi] == 2; if (e_hit) m_data[pi] = p_wdata; end
                    2: if (th && m_st[pi] != 0) begin
                           m_issue = 1; m_busy[pi] = 1; m_kind = 0; m_raddr = p_addr; m_rdata = m_data[pi];
                       end else e_done = 1;
                    3, 4: begin m_issue = 1; m_busy[pi] = 1; m_kind = p_op - 2; m_raddr = p_addr; m_rdata = 0; end
                    default: e_done = 1;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R9 p_ready", p_ready, !m_issue && !m_busy[hsh(p_addr)] && !c_valid);
            chk("R3 p_done", p_done, e_done);
            chk("R3 p_hit", p_hit, e_hit);
            chk("R3 p_rdata", p_rdata, e_rdata);
            chk("R5 d_req_valid", d_req_valid, m_issue);
            if (m_issue) begin
                chk("R5 d_req_kind", d_req_kind, m_kind);
                chk("R5 d_req_addr", d_req_addr, m_raddr);
                chk("R5 d_req_data", d_req_data, m_rdata);
            end
            chk("R8 c_rvalid", c_rvalid, e_crv);
            chk("R8 c_rdata", c_rdata, e_crd);
        end
    end

    // drive one processor op; returns outputs one cycle after acceptance
    task automatic proc(input logic [2:0] op, input logic [7:0] a, input logic [15:0] wd,
                        output logic dn, output logic ht, output logic [15:0] rd);
        @(negedge clk); #1;
        p_valid = 1; p_op = op; p_addr = a; p_wdata = wd;
        #1;
        while (!p_ready) begin @(negedge clk); #2; end
        @(posedge clk); #1;
        p_valid = 0;
        dn = p_done; ht = p_hit; rd = p_rdata;
    endtask

    task automatic cmd(input logic [1:0] k, input logic [7:0] a, input logic [1:0] s,
                       input logic [15:0] d, output logic rv, output logic [15:0] rdd);
        @(negedge clk); #1;
        c_valid = 1; c_kind = k; c_addr = a; c_state = s; c_data = d;
        @(posedge clk); #1;
        c_valid = 0;
        rv = c_rvalid; rdd = c_rdata;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic dn, ht, rv;
        logic [15:0] rd, rdd;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk); #2;
        chk("R1 ready after reset", p_ready, 1);
        chk("R1 no done after reset", p_done, 0);
        chk("R1 no request after reset", d_req_valid, 0);
        for (int l = 0; l < 4; l++) begin
            proc(3'd0, 8'(l), 0, dn, ht, rd);
            chk("R1 line invalid after reset", ht, 0);
        end
        // fill request with delayed acceptance
        proc(3'd3, 8'h14, 0, dn, ht, rd);
        chk("R5 no done before handshake", dn, 0);
        @(negedge clk); #2;
        chk("R5 shared request kind", d_req_kind, 1);
        chk("R5 request address", d_req_addr, 8'h14);
        chk("R9 stalled while pending", p_ready, 0);
        d_req_ready = 1;
        @(posedge clk); #1;
        d_req_ready = 0;
        chk("R5 done after handshake", p_done, 1);
        chk("R5 hit after handshake", p_hit, 1);
        // busy line stalls, another index does not
        @(negedge clk); #1;
        p_valid = 1; p_op = 0; p_addr = 8'h33; #1;
        chk("R9 busy index stalls", p_ready, 0);
        p_addr = 8'h20; #1;
        chk("R9 other index ready", p_ready, 1);
        c_valid = 1; c_kind = 2; c_addr = 8'h20; c_state = 0; #1;
        chk("R9 command blocks processor", p_ready, 0);
        p_valid = 0;
        @(posedge clk); #1 c_valid = 0;
        // fill shared
        cmd(2'd0, 8'h14, 2'd1, 16'hBEEF, rv, rdd);
        proc(3'd0, 8'h14, 0, dn, ht, rd);
        chk("R6 read hit after fill", ht, 1);
        chk("R6 fill data", rd, 16'hBEEF);
        proc(3'd1, 8'h14, 16'h5555, dn, ht, rd);
        chk("R4 write to shared misses", ht, 0);
        proc(3'd0, 8'h14, 0, dn, ht, rd);
        chk("R4 shared data unchanged", rd, 16'hBEEF);
        proc(3'd0, 8'h33, 0, dn, ht, rd);
        chk("R2 aliasing address misses", ht, 0);
        // exclusive
        d_req_ready = 1;
        proc(3'd4, 8'h14, 0, dn, ht, rd);
        @(posedge clk); #1;
        chk("R5 exclusive done", p_done, 1);
        d_req_ready = 0;
        cmd(2'd0, 8'h14, 2'd2, 16'h1111, rv, rdd);
        proc(3'd1, 8'h14, 16'h1234, dn, ht, rd);
        chk("R4 write exclusive hits", ht, 1);
        proc(3'd0, 8'h14, 0, dn, ht, rd);
        chk("R4 written data", rd, 16'h1234);
        proc(3'd6, 8'h14, 16'hFFFF, dn, ht, rd);
        chk("R11 unused op done", dn, 1);
        chk("R11 unused op miss", ht, 0);
        proc(3'd0, 8'h14, 0, dn, ht, rd);
        chk("R11 line unchanged", rd, 16'h1234);
        cmd(2'd3, 8'h14, 2'd1, 0, rv, rdd);
        chk("R8 data returned", rv, 1);
        chk("R8 returned value", rdd, 16'h1234);
        proc(3'd1, 8'h14, 16'h7777, dn, ht, rd);
        chk("R8 downgrade blocks write", ht, 0);
        cmd(2'd2, 8'h33, 2'd0, 0, rv, rdd);
        chk("R7 no data return", rv, 0);
        proc(3'd0, 8'h14, 0, dn, ht, rd);
        chk("R7 mismatched tag ignored", ht, 1);
        cmd(2'd2, 8'h14, 2'd0, 0, rv, rdd);
        proc(3'd0, 8'h14, 0, dn, ht, rd);
        chk("R7 invalidated line misses", ht, 0);
        // eviction
        proc(3'd2, 8'h20, 0, dn, ht, rd);
        chk("R5 evict of invalid line done", dn, 1);
        chk("R5 evict of invalid line miss", ht, 0);
        chk("R5 evict miss issues nothing", d_req_valid, 0);
        d_req_ready = 1;
        proc(3'd4, 8'h01, 0, dn, ht, rd);
        @(posedge clk); #1 d_req_ready = 0;
        cmd(2'd0, 8'h01, 2'd2, 16'h0A0A, rv, rdd);
        proc(3'd2, 8'h01, 0, dn, ht, rd);
        @(negedge clk); #2;
        chk("R5 evict kind", d_req_kind, 0);
        chk("R5 evict data", d_req_data, 16'h0A0A);
        d_req_ready = 1;
        @(posedge clk); #1 d_req_ready = 0;
        @(negedge clk); #1;
        p_valid = 1; p_op = 0; p_addr = 8'h01; #1;
        chk("R9 evicting line stalls", p_ready, 0);
        p_valid = 0;
        cmd(2'd1, 8'h01, 2'd0, 0, rv, rdd);
        proc(3'd0, 8'h01, 0, dn, ht, rd);
        chk("R10 acknowledged line invalid", ht, 0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule